// File: doc/BRIEF.md
# Prescaled Sample Tick Generator

This block produces the 16x oversampling enable that paces a UART's transmitter and receiver. The reference clock (a crystal or an external source) runs the whole block. A prescale stage divides the reference by 1 or by 4. A programmable 16-bit divisor then divides the prescaled rate. The result is a one-cycle pulse, `tick_o`, in the reference clock domain. Sixteen ticks make one serial bit time, so baud = reference / (prescale x divisor x 16). With a 14.7456 MHz reference and prescale 1, divisor 0x0060 gives 9600 baud and divisor 0x0001 gives 921.6 kbaud.

Software programs the block through a plain write port: two divisor byte registers and one control register, whose bit 7 selects the prescale ratio. Writes land in programmed registers straight away. The running counters take the new settings only at the next tick, so every tick period is whole. A two-state controller tracks whether new settings are waiting:
- `ST_SETTLED`: the running settings match the programmed ones. It moves to `ST_ARMED` on any accepted write.
- `ST_ARMED`: a change is waiting. On a tick with no write in the same cycle, it loads the programmed settings, restarts both counters and returns to `ST_SETTLED`. A write in the tick cycle keeps it in `ST_ARMED`.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor bytes are zero and the prescale ratio is 1, so `tick_o` is high on every reference cycle from the first cycle after reset is released.
- R2: A write to address 0 sets divisor bits 7:0, and a write to address 1 sets bits 15:8. With prescale 1 and divisor D (D >= 1), ticks occur every D reference cycles.
- R3: A write to address 2 sets the prescale ratio from data bit 7. A value of 1 gives divide-by-4, so the tick period is 4 x D cycles. A value of 0 gives divide-by-1, so the period is D cycles.
- R4: A divisor of 0 behaves exactly like a divisor of 1 (period 1 cycle at prescale 1, period 4 cycles at prescale 4).
- R5: `tick_o` is high for exactly one reference cycle per period and low in every other cycle of the period.
- R6: New settings take effect only at a tick. The period in which a write occurs keeps its old length, and the period after the next tick uses the new settings.
- R7: A write to address 3 changes nothing, and the tick period stays as it was.
- R8: With prescale 1, divisor 0x0060 gives a period of 96 cycles and divisor 0x0001 gives a tick on every cycle.
- R9: The largest divisor, 0xFFFF, at prescale 1 gives a period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 control, 3 unused |
| wr_data | input | 8 | Write data; in the control register, bit 7 selects divide-by-4 |
| tick_o | output | 1 | One-cycle 16x sample enable |

## Verification
The tick period is measured between consecutive pulses under several settings:
- Small divisors in each prescale mode show that the two ratios multiply rather than add.
- A divisor with only the high byte set shows that each byte lands in the right lane.
- Divisor zero shows that it is handled as one, and that the output never stalls.
- The largest divisor runs the counter through its full range.
- A write made in the middle of a period separates a reload at the next tick from an immediate restart: an immediate restart would shorten the current period.
- A write to the unused address shows that stray writes leave the period unchanged.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
    // Controller states: settled (running == programmed) or armed (reload waiting)
    typedef enum logic {
        ST_SETTLED = 1'b0,
        ST_ARMED   = 1'b1
    } bgen_state_e;

    localparam int DEF_DIV_W     = 16;
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_ADDR_W    = 2;
    localparam int DEF_PRE_RATIO = 4;
    localparam int DEF_SEL_BIT   = 7;
endpackage

// File: rtl/bgen_regs.sv
module bgen_regs #(
    parameter int DIV_W   = bgen_pkg::DEF_DIV_W,
    parameter int BYTE_W  = bgen_pkg::DEF_BYTE_W,
    parameter int ADDR_W  = bgen_pkg::DEF_ADDR_W,
    parameter int SEL_BIT = bgen_pkg::DEF_SEL_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  prog_div,
    output logic              prog_pre4,
    output logic              wr_hit
);
    localparam int NUM_LANES = DIV_W / BYTE_W;
    localparam int CTRL_ADDR = NUM_LANES;

    // One byte register per divisor lane, lane g at address g
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                lane_q <= wr_data;
            end
        end
        assign prog_div[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // Prescale select lives in one bit of the control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_pre4 <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            prog_pre4 <= wr_data[SEL_BIT];
        end
    end

    // Accepted write: any mapped address; others are dropped
    assign wr_hit = wr_en && (wr_addr <= ADDR_W'(CTRL_ADDR));
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
    parameter int PRE_RATIO = bgen_pkg::DEF_PRE_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    input  logic restart,
    output logic pre_en
);
    localparam int              PC_W = $clog2(PRE_RATIO);
    localparam logic [PC_W-1:0] LAST = PC_W'(PRE_RATIO - 1);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (restart || !slow_sel) begin
            pc_q <= '0;
        end else if (pc_q == LAST) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    // Divide-by-1 passes every cycle; divide-by-N fires on the last count
    assign pre_en = !slow_sel || (pc_q == LAST);
endmodule

// File: rtl/bgen_divcnt.sv
module bgen_divcnt #(
    parameter int DIV_W = bgen_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             term
);
    logic [DIV_W-1:0] dc_q;
    logic [DIV_W-1:0] last_cnt;

    // Zero divisor folds onto one: last count is 0 in both cases
    assign last_cnt = (limit == '0) ? '0 : limit - DIV_W'(1);
    assign term     = step && (dc_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q <= '0;
        end else if (restart) begin
            dc_q <= '0;
        end else if (step) begin
            dc_q <= term ? '0 : dc_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/bgen_ctrl.sv
module bgen_ctrl
    import bgen_pkg::*;
#(
    parameter int DIV_W = bgen_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             tick,
    input  logic [DIV_W-1:0] prog_div,
    input  logic             prog_pre4,
    output logic [DIV_W-1:0] act_div,
    output logic             act_pre4,
    output logic             reload,
    output bgen_state_e      state
);
    bgen_state_e st_q, st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SETTLED;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions; a write always wins over the load
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_SETTLED: if (wr_hit)         st_nxt = ST_ARMED;
            ST_ARMED:   if (!wr_hit && tick) st_nxt = ST_SETTLED;
            default:                         st_nxt = ST_SETTLED;
        endcase
    end

    // Outputs: load strobe only at a terminal count while armed
    always_comb begin
        reload = 1'b0;
        unique case (st_q)
            ST_SETTLED: reload = 1'b0;
            ST_ARMED:   reload = tick;
            default:    reload = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div  <= '0;
            act_pre4 <= 1'b0;
        end else if (reload) begin
            act_div  <= prog_div;
            act_pre4 <= prog_pre4;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bgen_pkg::*;
#(
    parameter int DIV_W     = bgen_pkg::DEF_DIV_W,
    parameter int BYTE_W    = bgen_pkg::DEF_BYTE_W,
    parameter int ADDR_W    = bgen_pkg::DEF_ADDR_W,
    parameter int PRE_RATIO = bgen_pkg::DEF_PRE_RATIO,
    parameter int SEL_BIT   = bgen_pkg::DEF_SEL_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick_o
);
    logic [DIV_W-1:0] prog_div;
    logic             prog_pre4;
    logic             wr_hit;
    logic [DIV_W-1:0] act_div;
    logic             act_pre4;
    logic             reload;
    logic             pre_en;
    bgen_state_e      state;

    bgen_regs #(
        .DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_div(prog_div), .prog_pre4(prog_pre4),
        .wr_hit(wr_hit)
    );

    bgen_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .tick(tick_o),
        .prog_div(prog_div), .prog_pre4(prog_pre4), .act_div(act_div),
        .act_pre4(act_pre4), .reload(reload), .state(state)
    );

    bgen_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_sel(act_pre4), .restart(reload),
        .pre_en(pre_en)
    );

    bgen_divcnt #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .step(pre_en), .restart(reload),
        .limit(act_div), .term(tick_o)
    );
endmodule

// File: rtl/bgen_checker.sv
module bgen_checker
    import bgen_pkg::*;
#(
    parameter int DIV_W  = bgen_pkg::DEF_DIV_W,
    parameter int BYTE_W = bgen_pkg::DEF_BYTE_W,
    parameter int ADDR_W = bgen_pkg::DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              wr_hit,
    input logic              tick_o,
    input logic              pre_en,
    input logic [DIV_W-1:0]  act_div,
    input logic              act_pre4,
    input logic [DIV_W-1:0]  prog_div,
    input bgen_state_e       state
);
    AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> prog_div[BYTE_W-1:0] == $past(wr_data)); // R2

    AST_TICK_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> pre_en); // R3

    AST_FAST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_pre4 && act_div <= DIV_W'(1)) |-> tick_o); // R4

    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pre4 && tick_o && state == ST_SETTLED) |=> !tick_o); // R5

    AST_LOAD_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_div) || !$stable(act_pre4)) |-> $past(tick_o)); // R6

    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> state == ST_ARMED); // R6

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(prog_div)); // R7
endmodule

bind baud_tick_gen bgen_checker #(
    .DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_hit(wr_hit), .tick_o(tick_o), .pre_en(pre_en),
    .act_div(act_div), .act_pre4(act_pre4), .prog_div(prog_div),
    .state(state)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_o(tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Advance until a tick is seen at a falling edge
    task automatic sync_tick();
        do @(negedge clk); while (!tick_o);
    endtask

    // Cycles from the current tick to the next one
    task automatic next_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_o);
    endtask

    task automatic configure(input int div, input bit pre4);
        write_reg(2'd0, div[7:0]);
        write_reg(2'd1, div[15:8]);
        write_reg(2'd2, {pre4, 7'd0});
        sync_tick();
    endtask

    task automatic t_reset();
        int hi = 0;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick_o) hi++;
        end
        check("R1 tick every cycle after reset", hi, 8);
    endtask

    task automatic t_examples();
        int n;
        configure(16'h0060, 1'b0);
        next_gap(n); check("R8 divisor 0x0060 period", n, 96);
        next_gap(n); check("R8 divisor 0x0060 repeat", n, 96);
        configure(16'h0001, 1'b0);
        next_gap(n); check("R8 divisor 0x0001 period", n, 1);
    endtask

    task automatic t_lanes();
        int n;
        configure(16'h0103, 1'b0);
        next_gap(n); check("R2 high and low lanes period", n, 259);
        configure(16'h0007, 1'b0);
        next_gap(n); check("R2 low lane period", n, 7);
    endtask

    task automatic t_prescale();
        int n;
        configure(16'h0005, 1'b1);
        next_gap(n); check("R3 divide-by-4 period", n, 20);
        write_reg(2'd2, 8'h7F);
        sync_tick();
        next_gap(n); check("R3 back to divide-by-1", n, 5);
    endtask

    task automatic t_zero();
        int n;
        configure(16'h0000, 1'b0);
        next_gap(n); check("R4 zero divisor prescale 1", n, 1);
        configure(16'h0000, 1'b1);
        next_gap(n); check("R4 zero divisor prescale 4", n, 4);
    endtask

    task automatic t_pulse();
        int hi = 0;
        configure(16'h0001, 1'b1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tick_o) hi++;
        end
        check("R5 one high cycle per 4", hi, 3);
        configure(16'h0003, 1'b0);
        hi = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (tick_o) hi++;
        end
        check("R5 one high cycle per 3", hi, 3);
    endtask

    task automatic t_midwrite();
        int cnt = 0;
        int n;
        configure(16'h000A, 1'b0);
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) wr_en = 1'b0;
            if (cnt == 2) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd20; end
        end while (!tick_o);
        wr_en = 1'b0;
        check("R6 period holding the write keeps old length", cnt, 10);
        next_gap(n); check("R6 next period uses new divisor", n, 20);
    endtask

    task automatic t_stray();
        int n;
        configure(16'h0007, 1'b0);
        write_reg(2'd3, 8'hFF);
        sync_tick();
        next_gap(n); check("R7 address 3 write ignored", n, 7);
        next_gap(n); check("R7 period still unchanged", n, 7);
    endtask

    task automatic t_max();
        int n;
        configure(16'hFFFF, 1'b0);
        next_gap(n); check("R9 largest divisor period", n, 65535);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_examples();
        t_lanes();
        t_prescale();
        t_zero();
        t_pulse();
        t_midwrite();
        t_stray();
        t_max();
        t_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule